// File: doc/BRIEF.md
# SD Command Path Engine

This block runs the command half of an SD host link. On a start strobe it serialises one 48-bit command frame onto the CMD line and then, depending on the requested response kind, listens for the card's reply. A reply may be a short 48-bit frame, a long 136-bit frame, or a short frame followed by a busy period signalled on DAT0. When the exchange ends, the engine checks the reply, stores its payload and records the result in a small set of write-one-to-clear status bits. Each status bit has an enable that lets it latch and a second enable that lets it raise the interrupt.

One card clock is one `clk` cycle. The engine drives the CMD line only while it is sending. It samples the line (`cmd_in`) on every cycle, and it treats a line level that differs from the level it is driving as a bus conflict. After any error the engine stays busy until a command-path reset pulse. That pulse clears the error bits and returns the engine to idle.

States and transitions: IDLE goes to SEND on an accepted start. SEND goes to IDLE after the last frame bit when no response is expected. Otherwise SEND goes to WAIT, or to HALT on a conflict. WAIT goes to RECV on a start bit and to HALT on timeout. RECV goes to HALT on a check error, to BUSY for the busy response kind, and to IDLE otherwise. BUSY goes to IDLE when DAT0 is high and to HALT on busy timeout. HALT goes to IDLE on command-path reset, and a command-path reset forces IDLE from every state.

Top module: `sdcmd_engine`

## Requirements
- R1: The outgoing frame is sent MSB first, one bit per cycle, with `cmd_oe` high. The 48 bits are, in order: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, zero seed) over those first 40 bits, and a 1 end bit. While `cmd_oe` is low, `cmd_out` rests high.
- R2: `inhibit` rises on the edge that accepts `start` and stays high for the whole exchange. A `start` seen while `inhibit` is high is ignored and does not alter the frame being sent.
- R3: Response kind `rsp_type`=0 means no response. The command ends on the edge that sends the end bit. `status` then equals 5'b00001 (bit 0 is command complete) and `inhibit` is low.
- R4: Kind 2 (short response) stores response bits 39:8 in `resp[31:0]` and zeroes `resp[127:32]`. A clean reply sets only status bit 0.
- R5: Kind 1 (long response) stores response bits 127:8 in `resp[119:0]` with `resp[127:120]` zero. The CRC covers response bits 127:8, and the index check is never applied, even when `idx_chk_en` is 1.
- R6: For kinds 2 and 3 with `idx_chk_en`=1, a response index field (bits 45:40) that differs from `cmd_idx` sets status bit 4. With `idx_chk_en`=0 the same reply completes cleanly.
- R7: With `crc_chk_en`=1, a reply whose CRC7 does not match sets status bit 2. With `crc_chk_en`=0 it completes cleanly.
- R8: A reply whose end bit is 0 sets status bit 3.
- R9: If no start bit (0) appears within `RSP_TIMEOUT` cycles after the frame ends, status bit 1 (timeout) is set. A start bit on the last allowed cycle is still accepted.
- R10: If `cmd_in` differs from the driven bit during SEND, driving stops and status bits 1 and 2 are both set. This pair marks a line conflict.
- R11: After any error, `inhibit` stays high and `start` is ignored. A `cmd_path_rst` pulse clears status bits 4:1 and leaves `inhibit` low on the next cycle.
- R12: Kind 3 waits after a clean short reply until `dat0_in` is high, with `inhibit` held high, and then sets bit 0. If DAT0 stays low for `BUSY_TIMEOUT` cycles, status bit 1 is set instead.
- R13: Writing `sts_wdata` with `sts_wr` clears the status bits written as 1. A bit whose `sts_en` is 0 never latches. `irq` is high exactly when some latched bit also has its `sig_en` bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe for a new command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 2 | 0 none, 1 long, 2 short, 3 short with busy |
| idx_chk_en | input | 1 | Enable response index check |
| crc_chk_en | input | 1 | Enable response CRC check |
| cmd_path_rst | input | 1 | Command-path reset pulse |
| cmd_in | input | 1 | Sensed CMD line level |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| dat0_in | input | 1 | DAT0 level, low while card busy |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 5 | Write-one-to-clear mask |
| sts_en | input | 5 | Per-bit latch enables |
| sig_en | input | 5 | Per-bit interrupt enables |
| status | output | 5 | Bit 0 complete, 1 timeout, 2 CRC, 3 end bit, 4 index |
| irq | output | 1 | Interrupt request |
| resp | output | 128 | Stored response payload |
| inhibit | output | 1 | Command in progress or halted |

## Verification
The bench sweeps indices and arguments and compares each sent frame with a CRC7 computed on its own, anchored by the known all-zero reset frame, so a misplaced or wrongly seeded CRC would corrupt every frame. It places the response start bit one cycle before and exactly at the timeout limit, where an off-by-one timer would reject a legal reply or wait one cycle too long. It feeds long replies with an all-ones index while the index check is enabled, which catches a design that checks the index on long replies and flags a false error. It also jams the line during send to look for the timeout-plus-CRC pair, pokes `start` mid-exchange to catch a design that re-latches the frame, and holds DAT0 low past the busy limit to catch a busy wait that never ends.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_BUSY,
        ST_HALT
    } sdcmd_state_t;

    localparam int NUM_STS   = 5;
    localparam int STS_DONE  = 0;
    localparam int STS_TOUT  = 1;
    localparam int STS_CRC   = 2;
    localparam int STS_ENDB  = 3;
    localparam int STS_INDEX = 4;

    localparam logic [1:0] RSP_NONE  = 2'd0;
    localparam logic [1:0] RSP_LONG  = 2'd1;
    localparam logic [1:0] RSP_SHORT = 2'd2;
    localparam logic [1:0] RSP_BUSY  = 2'd3;

    // CRC7 with polynomial x^7 + x^3 + 1 over a 40-bit head, MSB first
    function automatic logic [6:0] crc7_head(input logic [39:0] head);
        logic [6:0] r;
        logic       fb;
        r = '0;
        for (int i = 39; i >= 0; i--) begin
            fb = head[i] ^ r[6];
            r  = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return r;
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    logic fb;
    assign fb = din ^ crc[6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   crc <= '0;
        else if (clr) crc <= '0;
        else if (en)  crc <= {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         clr_err,
    input  logic [W-1:0] sts_en,
    input  logic [W-1:0] sig_en,
    output logic [W-1:0] status,
    output logic         irq
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        localparam bit IS_ERR = (b != 0);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       status[b] <= 1'b0;
            else if (IS_ERR && clr_err)       status[b] <= 1'b0;
            else if (set[b] && sts_en[b])     status[b] <= 1'b1;
            else if (wr && wdata[b])          status[b] <= 1'b0;
        end
    end

    assign irq = |(status & sig_en);
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int RSP_TIMEOUT  = 64,
    parameter int BUSY_TIMEOUT = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [5:0]   cmd_idx,
    input  logic [31:0]  cmd_arg,
    input  logic [1:0]   rsp_type,
    input  logic         idx_chk_en,
    input  logic         crc_chk_en,
    input  logic         cmd_path_rst,
    input  logic         cmd_in,
    output logic         cmd_out,
    output logic         cmd_oe,
    input  logic         dat0_in,
    input  logic         sts_wr,
    input  logic [4:0]   sts_wdata,
    input  logic [4:0]   sts_en,
    input  logic [4:0]   sig_en,
    output logic [4:0]   status,
    output logic         irq,
    output logic [127:0] resp,
    output logic         inhibit
);
    localparam int TMAX = (BUSY_TIMEOUT > RSP_TIMEOUT) ? BUSY_TIMEOUT : RSP_TIMEOUT;
    localparam int TW   = $clog2(TMAX) + 1;
    localparam logic [TW-1:0] RSP_LIM  = TW'(RSP_TIMEOUT - 1);
    localparam logic [TW-1:0] BUSY_LIM = TW'(BUSY_TIMEOUT - 1);

    sdcmd_state_t     state_q, state_d;
    logic [7:0]       cnt_q;
    logic [47:0]      tx_q;
    logic [126:0]     rx_q;
    logic [TW-1:0]    tmr_q;
    logic [1:0]       typ_q;
    logic [5:0]       idx_q;
    logic             ichk_q, cchk_q;
    logic [127:0]     resp_q;
    logic [NUM_STS-1:0] sts_set;
    logic             crc_clr, crc_en, last_bit;
    logic [6:0]       rx_crc;
    logic [7:0]       last_cnt;
    logic [39:0]      head;

    assign head     = {2'b01, cmd_idx, cmd_arg};
    assign last_cnt = (typ_q == RSP_LONG) ? 8'd135 : 8'd47;
    assign last_bit = (state_q == ST_RECV) && (cnt_q == last_cnt);

    sdcmd_crc7 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(cmd_in), .crc(rx_crc)
    );

    sdcmd_status #(.W(NUM_STS)) u_sts (
        .clk(clk), .rst_n(rst_n), .set(sts_set), .wr(sts_wr),
        .wdata(sts_wdata), .clr_err(cmd_path_rst), .sts_en(sts_en),
        .sig_en(sig_en), .status(status), .irq(irq)
    );

    // next state and status events
    always_comb begin
        state_d = state_q;
        sts_set = '0;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: begin
                if (cmd_in != tx_q[47]) begin
                    sts_set[STS_TOUT] = 1'b1;
                    sts_set[STS_CRC]  = 1'b1;
                    state_d = ST_HALT;
                end else if (cnt_q == 8'd47) begin
                    if (typ_q == RSP_NONE) begin
                        sts_set[STS_DONE] = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                crc_clr = 1'b1;
                if (!cmd_in) state_d = ST_RECV;
                else if (tmr_q == RSP_LIM) begin
                    sts_set[STS_TOUT] = 1'b1;
                    state_d = ST_HALT;
                end
            end
            ST_RECV: begin
                crc_en = (typ_q == RSP_LONG) ? (cnt_q >= 8'd8 && cnt_q <= 8'd134)
                                             : (cnt_q <= 8'd46);
                if (last_bit) begin
                    sts_set[STS_ENDB]  = !cmd_in;
                    sts_set[STS_CRC]   = cchk_q && (rx_crc != 7'd0);
                    sts_set[STS_INDEX] = ichk_q && (typ_q != RSP_LONG) && (rx_q[44:39] != idx_q);
                    if (!cmd_in || (cchk_q && rx_crc != 7'd0) ||
                        (ichk_q && typ_q != RSP_LONG && rx_q[44:39] != idx_q))
                        state_d = ST_HALT;
                    else if (typ_q == RSP_BUSY)
                        state_d = ST_BUSY;
                    else begin
                        sts_set[STS_DONE] = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_BUSY: begin
                if (dat0_in) begin
                    sts_set[STS_DONE] = 1'b1;
                    state_d = ST_IDLE;
                end else if (tmr_q == BUSY_LIM) begin
                    sts_set[STS_TOUT] = 1'b1;
                    state_d = ST_HALT;
                end
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
        if (cmd_path_rst) begin
            state_d = ST_IDLE;
            sts_set = '0;
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tx_q    <= '1;
            rx_q    <= '0;
            tmr_q   <= '0;
            typ_q   <= RSP_NONE;
            idx_q   <= '0;
            ichk_q  <= 1'b0;
            cchk_q  <= 1'b0;
            resp_q  <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= (state_d != state_q) ? '0 : tmr_q + 1'b1;
            if (state_q == ST_IDLE && start) begin
                tx_q   <= {head, crc7_head(head), 1'b1};
                typ_q  <= rsp_type;
                idx_q  <= cmd_idx;
                ichk_q <= idx_chk_en;
                cchk_q <= crc_chk_en;
                cnt_q  <= '0;
            end else if (state_q == ST_SEND) begin
                tx_q  <= {tx_q[46:0], 1'b0};
                cnt_q <= cnt_q + 8'd1;
            end else if (state_q == ST_WAIT) begin
                cnt_q <= 8'd1;
                rx_q  <= {rx_q[125:0], cmd_in};
            end else if (state_q == ST_RECV) begin
                cnt_q <= cnt_q + 8'd1;
                rx_q  <= {rx_q[125:0], cmd_in};
            end
            if (last_bit)
                resp_q <= (typ_q == RSP_LONG) ? {8'd0, rx_q[126:7]}
                                              : {96'd0, rx_q[38:7]};
        end
    end

    // outputs
    always_comb begin
        cmd_oe  = (state_q == ST_SEND);
        cmd_out = cmd_oe ? tx_q[47] : 1'b1;
        inhibit = (state_q != ST_IDLE);
        resp    = resp_q;
    end
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_path_rst,
    input logic       cmd_oe,
    input logic       cmd_out,
    input logic       inhibit,
    input logic [4:0] status
);
    AST_LINE_RESTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out); // R1

    AST_DRIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> inhibit); // R2

    AST_NO_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !cmd_oe && !cmd_path_rst) |=> !cmd_oe); // R2

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> (status[4:1] == 4'd0)); // R3

    AST_PATH_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_path_rst |=> (status[4:1] == 4'd0 && !inhibit)); // R11
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_path_rst(cmd_path_rst), .cmd_oe(cmd_oe),
    .cmd_out(cmd_out), .inhibit(inhibit), .status(status)
);

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;
    logic         clk = 0, rst_n = 0, start = 0;
    logic [5:0]   cmd_idx = 0;
    logic [31:0]  cmd_arg = 0;
    logic [1:0]   rsp_type = 0;
    logic         idx_chk_en = 0, crc_chk_en = 0, cmd_path_rst = 0;
    logic         card_drv = 1, jam = 0, dat0_in = 1;
    logic         sts_wr = 0;
    logic [4:0]   sts_wdata = 0, sts_en = 5'h1F, sig_en = 0;
    wire          cmd_out, cmd_oe, irq, inhibit, line;
    wire  [4:0]   status;
    wire  [127:0] resp;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [4:0] S_DONE = 5'b00001, S_TO = 5'b00010, S_CRC = 5'b00100,
                           S_END = 5'b01000, S_IDX = 5'b10000;

    assign line = cmd_oe ? (cmd_out & ~jam) : card_drv;

    always #2.5 clk = ~clk;

    sdcmd_engine #(.RSP_TIMEOUT(64), .BUSY_TIMEOUT(32)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .rsp_type(rsp_type), .idx_chk_en(idx_chk_en), .crc_chk_en(crc_chk_en),
        .cmd_path_rst(cmd_path_rst), .cmd_in(line), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .dat0_in(dat0_in), .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_en(sts_en),
        .sig_en(sig_en), .status(status), .irq(irq), .resp(resp), .inhibit(inhibit)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_bits(input logic [135:0] v, input int n);
        logic [6:0] r = 0;
        for (int i = n - 1; i >= 0; i--)
            r = {r[5:0], 1'b0} ^ ((v[i] ^ r[6]) ? 7'h09 : 7'h00);
        return r;
    endfunction

    function automatic logic [47:0] mk48(input logic [5:0] idx, input logic [31:0] a, input logic dir);
        logic [39:0] h = {1'b0, dir, idx, a};
        return {h, crc_bits({96'd0, h}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] mk136(input logic [119:0] p);
        return {2'b00, 6'h3F, p, crc_bits({16'd0, p}, 120), 1'b1};
    endfunction

    task automatic run(input logic [5:0] idx, input logic [31:0] a, input logic [1:0] typ,
                       input logic ic, input logic cc, input int dly, input logic [135:0] frm,
                       input int flen, input int busy, input int poke, output logic [47:0] seen);
        @(negedge clk);
        cmd_idx = idx; cmd_arg = a; rsp_type = typ; idx_chk_en = ic; crc_chk_en = cc;
        start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 48; i++) begin
            if (i == 0) check("R2 inhibit during send", inhibit, 1);
            seen[47 - i] = cmd_out;
            if (i == poke) begin start = 1; cmd_idx = ~idx; end
            else start = 0;
            @(negedge clk);
        end
        start = 0;
        if (flen > 0) begin
            for (int d = 0; d < dly; d++) begin card_drv = 1; @(negedge clk); end
            for (int k = 0; k < flen; k++) begin
                card_drv = frm[flen - 1 - k];
                if (k == flen - 1 && typ == 2'd3) dat0_in = 0;
                @(negedge clk);
            end
            card_drv = 1;
            if (typ == 2'd3) begin
                repeat (busy) @(negedge clk);
                check("R12 busy holds inhibit", inhibit, 1);
                dat0_in = 1;
            end
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_sts();
        @(negedge clk); sts_wr = 1; sts_wdata = 5'h1F;
        @(negedge clk); sts_wr = 0; sts_wdata = 0;
    endtask

    task automatic path_rst();
        @(negedge clk); cmd_path_rst = 1;
        @(negedge clk); cmd_path_rst = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] seen, f48;
        logic [135:0] f136;
        logic [119:0] pay;
        logic [31:0] a, ra;
        logic [5:0] ix;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        check("R13 reset status", status, 0);
        check("R2 reset inhibit", inhibit, 0);
        check("R1 reset line idle", {cmd_oe, cmd_out}, 2'b01);
        check("R13 reset irq", irq, 0);

        // R1 R3: known zero frame, no response
        run(6'd0, 32'd0, 2'd0, 0, 0, 0, 0, 0, 0, -1, seen);
        check("R1 zero frame", seen, 48'h40_0000_0000_95);
        check("R3 done only", status, S_DONE);
        check("R3 inhibit low", inhibit, 0);
        clear_sts();

        // R1 R4: sweep of short exchanges
        for (int i = 0; i < 8; i++) begin
            ix = 6'((i * 9 + 5) % 64);
            a  = 32'h1357_9BDF * (i + 1) ^ (32'hA5 << i);
            ra = ~a + i;
            run(ix, a, 2'd2, 1, 1, i * 3, {88'd0, mk48(ix, ra, 1'b0)}, 48, 0, -1, seen);
            check("R1 frame sweep", seen, mk48(ix, a, 1'b1));
            check("R4 short payload", resp, {96'd0, ra});
            check("R4 clean status", status, S_DONE);
            clear_sts();
        end

        // R5: long reply, index check enabled but not applied
        for (int i = 0; i < 3; i++) begin
            pay = {4{30'h2A5F_0C31 + 30'(i * 77)}};
            run(6'd2, 32'h0, 2'd1, 1, 1, 2, mk136(pay), 136, 0, -1, seen);
            check("R5 long payload", resp, {8'd0, pay});
            check("R5 long clean", status, S_DONE);
            clear_sts();
        end

        // R6: index mismatch
        run(6'd17, 32'h5, 2'd2, 1, 1, 1, {88'd0, mk48(6'd18, 32'h77, 1'b0)}, 48, 0, -1, seen);
        check("R6 index error", status, S_IDX);
        path_rst(); clear_sts();
        run(6'd17, 32'h5, 2'd2, 0, 1, 1, {88'd0, mk48(6'd18, 32'h77, 1'b0)}, 48, 0, -1, seen);
        check("R6 index check off", status, S_DONE);
        clear_sts();

        // R7: bad CRC
        f48 = mk48(6'd7, 32'hCAFE_F00D, 1'b0) ^ 48'h4;
        run(6'd7, 32'h1, 2'd2, 1, 1, 1, {88'd0, f48}, 48, 0, -1, seen);
        check("R7 crc error", status, S_CRC);
        path_rst(); clear_sts();
        run(6'd7, 32'h1, 2'd2, 1, 0, 1, {88'd0, f48}, 48, 0, -1, seen);
        check("R7 crc check off", status, S_DONE);
        clear_sts();
        f136 = mk136(120'h1) ^ 136'h10;
        run(6'd9, 32'h1, 2'd1, 0, 1, 1, f136, 136, 0, -1, seen);
        check("R7 long crc error", status, S_CRC);
        path_rst(); clear_sts();

        // R8: end bit low
        f48 = mk48(6'd3, 32'h1234, 1'b0) & ~48'h1;
        run(6'd3, 32'h0, 2'd2, 1, 1, 1, {88'd0, f48}, 48, 0, -1, seen);
        check("R8 end bit error", status, S_END);
        path_rst(); clear_sts();

        // R9: timeout boundary
        run(6'd8, 32'h0, 2'd2, 1, 1, 63, {88'd0, mk48(6'd8, 32'h9, 1'b0)}, 48, 0, -1, seen);
        check("R9 start bit on last cycle", status, S_DONE);
        clear_sts();
        run(6'd8, 32'h0, 2'd2, 1, 1, 64, {88'd0, mk48(6'd8, 32'h9, 1'b0)}, 48, 0, -1, seen);
        check("R9 timeout", status, S_TO);
        path_rst(); clear_sts();

        // R10: line conflict
        jam = 1;
        run(6'd1, 32'h0, 2'd2, 1, 1, 0, 0, 0, 0, -1, seen);
        jam = 0;
        check("R10 conflict pair", status, S_TO | S_CRC);
        check("R10 drive stopped", cmd_oe, 0);

        // R11: halted engine ignores start until path reset
        check("R11 halted inhibit", inhibit, 1);
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        @(negedge clk);
        check("R11 start ignored", cmd_oe, 0);
        path_rst();
        check("R11 errors cleared", status[4:1], 0);
        check("R11 released", inhibit, 0);
        clear_sts();

        // R2: start during send does not change frame
        run(6'd21, 32'hDEAD_BEEF, 2'd0, 0, 0, 0, 0, 0, 0, 10, seen);
        check("R2 poke ignored", seen, mk48(6'd21, 32'hDEAD_BEEF, 1'b1));
        check("R2 single completion", status, S_DONE);
        clear_sts();

        // R12: busy wait and busy timeout
        run(6'd12, 32'h0, 2'd3, 1, 1, 2, {88'd0, mk48(6'd12, 32'h44, 1'b0)}, 48, 20, -1, seen);
        check("R12 busy done", status, S_DONE);
        clear_sts();
        run(6'd12, 32'h0, 2'd3, 1, 1, 2, {88'd0, mk48(6'd12, 32'h44, 1'b0)}, 48, 40, -1, seen);
        check("R12 busy timeout", status, S_TO);
        path_rst(); clear_sts();

        // R13: w1c, enables, interrupt
        run(6'd0, 32'd0, 2'd0, 0, 0, 0, 0, 0, 0, -1, seen);
        @(negedge clk); sts_wr = 1; sts_wdata = 5'h1E; @(negedge clk); sts_wr = 0;
        check("R13 write zero keeps bit", status, S_DONE);
        check("R13 irq masked", irq, 0);
        sig_en = 5'h01; #1;
        check("R13 irq raised", irq, 1);
        sig_en = 5'h1E; #1;
        check("R13 irq other enables", irq, 0);
        sig_en = 0;
        clear_sts();
        check("R13 w1c cleared", status, 0);
        sts_en = 5'h1E;
        run(6'd0, 32'd0, 2'd0, 0, 0, 0, 0, 0, 0, -1, seen);
        check("R13 latch disabled", status, 0);
        sts_en = 5'h1F;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule